// File: doc/BRIEF.md
# Page-Aligned Program Request Splitter

This block sits in front of a serial flash programming engine. It takes one program request, a start address and a byte count, and turns it into a sequence of chunk commands. Each chunk has an address and a length, and no chunk runs past the end of a 256-byte page. A request that starts partway into a page first gets a short chunk that reaches the next page boundary. Each chunk after that covers a whole page, except for the final one, which carries whatever bytes are left.

Requests and chunks each use a valid/ready handshake. The block sends out one chunk at a time and holds it steady until the downstream engine accepts it. While chunks from one request are still pending, it accepts no new request.

Every request ends with a completion pulse. That pulse reports the total number of bytes handed downstream and an error flag. A request that would run past the end of the device is refused without producing any chunk. A request with a byte count of zero completes at once.

Top module: `page_split`

## Requirements
- R1: After reset, `req_ready` is 1, `chk_valid` is 0 and `done_valid` is 0.
- R2: When (start mod 256) + length <= 256, exactly one chunk is emitted, with address = start and length = length.
- R3: When (start mod 256) + length > 256, the first chunk has address = start and length = 256 - (start mod 256).
- R4: Every chunk after the first has length min(256, bytes not yet emitted). No chunk is longer than 256 or crosses a page boundary.
- R5: Each chunk address equals the start address plus the sum of the lengths of all earlier chunks of the same request.
- R6: While `chk_valid` is 1 and `chk_ready` is 0, `chk_valid`, `chk_addr` and `chk_len` keep their values into the next cycle.
- R7: From the cycle after a request with a non-zero length is accepted until its last chunk is taken, `req_ready` is 0. Any request presented during that time is ignored and does not change the chunks produced.
- R8: A request with start + length greater than the device size (parameter `DEV_BYTES`, default 1 MiB) produces no chunk. In the cycle after acceptance it yields `done_valid` = 1, `done_err` = 1 and `done_count` = 0.
- R9: A request with length 0 and start within the device produces no chunk. In the cycle after acceptance it yields `done_valid` = 1, `done_err` = 0 and `done_count` = 0.
- R10: In the cycle after the last chunk handshake, `done_valid` is 1 for exactly one cycle, with `done_err` = 0 and `done_count` equal to the sum of all chunk lengths of the request.
- R11: A request ending exactly at the device size (start + length = `DEV_BYTES`) is accepted and split normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count of the request |
| chk_valid | output | 1 | Chunk command present |
| chk_ready | input | 1 | Downstream takes the chunk |
| chk_addr | output | ADDR_W | Chunk start address |
| chk_len | output | log2(PAGE_BYTES)+1 | Chunk byte count (1 to PAGE_BYTES) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request was refused as out of range |
| done_count | output | LEN_W | Total bytes handed downstream |

## Verification
The first chunk appears one cycle after the request handshake. Each following chunk appears one cycle after the previous chunk handshake. The completion pulse comes one cycle after the last chunk handshake, or one cycle after acceptance for a refused or empty request. The bench drives all inputs and samples all outputs on the falling edge. In each falling-edge sample it compares the current chunk against the value its own page arithmetic predicts from the handshakes it has already made. Once the last chunk has been taken, the next sample must show the completion pulse and the sample after it must show the pulse gone. Handshakes are stalled on alternate cycles so that a held chunk is compared again in the following cycle.

// File: rtl/page_split_pkg.sv
package page_split_pkg;

  typedef enum logic {
    SP_IDLE = 1'b0,
    SP_EMIT = 1'b1
  } sp_state_e;

endpackage

// File: rtl/page_split_guard.sv
module page_split_guard #(
  parameter int              ADDR_W    = 24,
  parameter int              LEN_W     = 24,
  parameter longint unsigned DEV_BYTES = 64'h100000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              is_empty,
  output logic              is_oob
);

  function automatic logic past_end(input logic [ADDR_W-1:0] a,
                                    input logic [LEN_W-1:0]  n);
    logic [63:0] end_pos;
    end_pos = 64'(a) + 64'(n);
    return end_pos > DEV_BYTES;
  endfunction

  assign is_oob   = past_end(addr, len);
  assign is_empty = (len == '0);

endmodule

// File: rtl/page_split_sizer.sv
module page_split_sizer #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         active,
  input  logic [ADDR_W-1:0]            cur_addr,
  input  logic [LEN_W-1:0]             remaining,
  output logic [$clog2(PAGE_BYTES):0]  chunk_len,
  output logic                         is_last
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CL_W  = OFF_W + 1;

  // bytes from cur_addr to the next page boundary
  function automatic logic [CL_W-1:0] page_room(input logic [ADDR_W-1:0] a);
    return CL_W'(PAGE_BYTES) - CL_W'(a[OFF_W-1:0]);
  endfunction

  logic [CL_W-1:0] room;

  assign room      = page_room(cur_addr);
  assign is_last   = (remaining <= LEN_W'(room));
  assign chunk_len = is_last ? CL_W'(remaining) : room;

  // R4
  chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (chunk_len != '0) && (chunk_len <= CL_W'(PAGE_BYTES)) &&
               ((CL_W+1)'(cur_addr[OFF_W-1:0]) + (CL_W+1)'(chunk_len) <= (CL_W+1)'(PAGE_BYTES)));

endmodule

// File: rtl/page_split_tally.sv
module page_split_tally #(
  parameter int LEN_W = 24,
  parameter int CL_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [CL_W-1:0]  add_len,
  input  logic             fin_ok,
  input  logic             fin_err,
  output logic             done_valid,
  output logic             done_err,
  output logic [LEN_W-1:0] done_count
);

  function automatic logic [LEN_W-1:0] bump(input logic [LEN_W-1:0] acc,
                                            input logic [CL_W-1:0]  inc);
    return acc + LEN_W'(inc);
  endfunction

  logic [LEN_W-1:0] total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q    <= '0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      if (clear)       total_q <= '0;
      else if (add_en) total_q <= bump(total_q, add_len);
      done_valid <= fin_ok | fin_err;
      done_err   <= fin_err;
    end
  end

  assign done_count = total_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R8
  err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err) |-> (done_count == '0));

endmodule

// File: rtl/page_split.sv
module page_split #(
  parameter int              ADDR_W     = 24,
  parameter int              LEN_W      = 24,
  parameter int              PAGE_BYTES = 256,
  parameter longint unsigned DEV_BYTES  = 64'h100000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  output logic                        chk_valid,
  input  logic                        chk_ready,
  output logic [ADDR_W-1:0]           chk_addr,
  output logic [$clog2(PAGE_BYTES):0] chk_len,
  output logic                        done_valid,
  output logic                        done_err,
  output logic [LEN_W-1:0]            done_count
);

  import page_split_pkg::*;

  localparam int CL_W = $clog2(PAGE_BYTES) + 1;

  sp_state_e         state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  remaining_q;

  // named events
  logic req_fire, chk_fire, last_fire;
  logic req_empty, req_oob, req_work;
  logic is_last;
  logic [CL_W-1:0] chunk_len;

  assign req_ready = (state_q == SP_IDLE);
  assign chk_valid = (state_q == SP_EMIT);
  assign req_fire  = req_valid & req_ready;
  assign chk_fire  = chk_valid & chk_ready;
  assign last_fire = chk_fire & is_last;
  assign req_work  = req_fire & ~req_oob & ~req_empty;

  page_split_guard #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)
  ) guard_i (
    .addr(req_addr), .len(req_len),
    .is_empty(req_empty), .is_oob(req_oob)
  );

  page_split_sizer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) sizer_i (
    .clk(clk), .rst_n(rst_n), .active(chk_valid),
    .cur_addr(cur_addr_q), .remaining(remaining_q),
    .chunk_len(chunk_len), .is_last(is_last)
  );

  page_split_tally #(
    .LEN_W(LEN_W), .CL_W(CL_W)
  ) tally_i (
    .clk(clk), .rst_n(rst_n),
    .clear(req_fire), .add_en(chk_fire), .add_len(chunk_len),
    .fin_ok(last_fire | (req_fire & req_empty & ~req_oob)),
    .fin_err(req_fire & req_oob),
    .done_valid(done_valid), .done_err(done_err), .done_count(done_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SP_IDLE;
      cur_addr_q  <= '0;
      remaining_q <= '0;
    end else begin
      if (req_work) begin
        state_q     <= SP_EMIT;
        cur_addr_q  <= req_addr;
        remaining_q <= req_len;
      end else if (chk_fire) begin
        cur_addr_q  <= cur_addr_q + ADDR_W'(chunk_len);
        remaining_q <= remaining_q - LEN_W'(chunk_len);
        if (is_last) state_q <= SP_IDLE;
      end
    end
  end

  assign chk_addr = cur_addr_q;
  assign chk_len  = chunk_len;

  // R6
  chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |=> chk_valid && $stable(chk_addr) && $stable(chk_len));

  // R5
  chunk_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && !is_last) |=> chk_valid && (chk_addr == $past(chk_addr + ADDR_W'(chk_len))));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_work |=> chk_valid && !req_ready && (chk_addr == $past(req_addr)));

  // R8
  reject_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_oob) |=> done_valid && done_err && !chk_valid);

  // R9
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_empty && !req_oob) |=> done_valid && !done_err && !chk_valid);

  // R10
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done_valid && !done_err && !chk_valid);

endmodule

// File: tb/page_split_tb_top.sv
`timescale 1ns/1ps
module page_split_tb_top;

  localparam int     AW   = 24;
  localparam int     LW   = 24;
  localparam int     PG   = 256;
  localparam longint DEV  = 64'h100000;
  localparam int     NVEC = 8;

  // {mode[1:0], addr[23:0], len[23:0]}; mode bit0 = stall, bit1 = hold request
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b00, 24'h000100, 24'd16},
    {2'b00, 24'h0001F0, 24'd16},
    {2'b01, 24'h0001F0, 24'd17},
    {2'b10, 24'h000005, 24'd700},
    {2'b01, 24'h000200, 24'd512},
    {2'b11, 24'h0003FF, 24'd258},
    {2'b00, 24'h00ABC0, 24'd1},
    {2'b00, 24'h000000, 24'd256}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic chk_ready = 1'b0;
  logic req_ready, chk_valid, done_valid, done_err;
  logic [AW-1:0] chk_addr;
  logic [8:0] chk_len;
  logic [LW-1:0] done_count;

  int n_checks = 0;
  int n_fails = 0;

  always #2.5 clk = ~clk;

  page_split dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_addr(chk_addr), .chk_len(chk_len),
    .done_valid(done_valid), .done_err(done_err), .done_count(done_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_req(input longint addr, input longint len, input bit stall, input bit hold);
    longint rem, eaddr, elen, total, off;
    bit first;
    int cyc;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 idle ready", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = AW'(addr);
    req_len   = LW'(len);
    @(negedge clk);
    if (hold) begin
      req_addr = 24'h0F0F0F;   // junk request held while busy
      req_len  = 24'd5;
    end else begin
      req_valid = 1'b0;
    end
    if (addr + len > DEV || len == 0) begin
      if (addr + len > DEV) begin
        check(done_valid && done_err, "R8 reject done", {done_valid, done_err}, 3);
        check(chk_valid == 1'b0, "R8 no chunk", chk_valid, 0);
        check(done_count == 0, "R8 count", done_count, 0);
      end else begin
        check(done_valid && !done_err, "R9 empty done", {done_valid, done_err}, 2);
        check(chk_valid == 1'b0, "R9 no chunk", chk_valid, 0);
        check(done_count == 0, "R9 count", done_count, 0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      check(done_valid == 1'b0, "R10 pulse ends", done_valid, 0);
      return;
    end
    rem = len; eaddr = addr; total = 0; first = 1'b1; cyc = 0;
    off = addr % PG;
    while (rem > 0) begin
      if (first) elen = (off + len <= PG) ? len : PG - off;
      else       elen = (rem < PG) ? rem : PG;
      check(chk_valid == 1'b1, "R2 chunk valid", chk_valid, 1);
      check(chk_addr == AW'(eaddr), "R5 chunk addr", chk_addr, eaddr);
      if (first && off + len <= PG) check(chk_len == 9'(elen), "R2 single len", chk_len, elen);
      else if (first)               check(chk_len == 9'(elen), "R3 first len", chk_len, elen);
      else if (cyc > 0 && stall)    check(chk_len == 9'(elen), "R6 held len", chk_len, elen);
      else                          check(chk_len == 9'(elen), "R4 later len", chk_len, elen);
      check(req_ready == 1'b0, "R7 busy", req_ready, 0);
      check(done_valid == 1'b0, "R10 no early done", done_valid, 0);
      chk_ready = stall ? cyc[0] : 1'b1;
      cyc++;
      if (chk_ready) begin
        eaddr += elen; rem -= elen; total += elen; first = 1'b0;
      end
      @(negedge clk);
    end
    chk_ready = 1'b0;
    req_valid = 1'b0;
    check(done_valid && !done_err, "R10 done", {done_valid, done_err}, 2);
    check(done_count == LW'(total), "R10 count", done_count, total);
    check(chk_valid == 1'b0, "R10 idle", chk_valid, 0);
    @(negedge clk);
    check(done_valid == 1'b0, "R10 pulse ends", done_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(chk_valid == 1'b0, "R1 chunk", chk_valid, 0);
    check(done_valid == 1'b0, "R1 done", done_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && chk_valid == 1'b0, "R1 after release", req_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      run_req(longint'(VEC[i][47:24]), longint'(VEC[i][23:0]), VEC[i][48], VEC[i][49]);
    end

    run_req(64'h001234, 0, 1'b0, 1'b0);          // R9 zero length
    run_req(DEV - 10, 11, 1'b0, 1'b0);           // R8 one byte past the end
    run_req(DEV - 300, 300, 1'b1, 1'b0);         // R11 ends exactly at device size
    run_req(DEV - 1, 1, 1'b0, 1'b0);             // R11 last byte
    run_req(64'h0FFFFF, 24'h000010, 1'b0, 1'b0); // R8 far past the end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule